// File: doc/BRIEF.md
# LCD Frame Sync Timing Generator

This block drives the horizontal and vertical sync lines of a serial-RGB LCD panel. The panel takes one 8-bit colour component per clock, so one 24-bit pixel spans three clocks. A typical line is 408 pixels, which is 1224 clocks, with a 90-clock sync pulse. A frame is 241 lines: 240 visible lines and one blanking line. The vertical sync is held low for three line periods.

There are two independent period/width pulse generators, and both count the same pixel clock. Channel 0 produces the horizontal sync and channel 1 produces the vertical sync. Each generator drives its sync output low for the first WIDTH clocks of every PERIOD clocks. Each one also raises a one-clock strobe on the last clock of every period. The period and width values are plain inputs, so the line length, the frame length and both pulse widths can be set at run time.

Software sets the vertical period to an exact multiple of the horizontal period. The vertical generator must run ahead of the horizontal one so that the two syncs keep a fixed phase. The block enforces this order itself. The horizontal generator can only run while the vertical one has already been enabled since the previous clock edge. As a result, turning both enables on together leaves the vertical sync exactly one clock ahead.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, both sync outputs are high (inactive) and both period strobes are low.
- R2: While a generator runs, its sync output is low for exactly WIDTH clocks at the start of every period. It is then high for the remaining PERIOD minus WIDTH clocks, so each period lasts exactly PERIOD clocks.
- R3: A generator's period strobe is high for exactly one clock per period: the last clock, the one in which the count wraps.
- R4: When a generator's enable is low at a clock edge, its sync output is high and its strobe is low from that edge on. When the enable is high again at an edge, the following clock is the first clock of a fresh period, with the sync low if WIDTH is nonzero.
- R5: The horizontal generator runs only at edges where the vertical generator has been enabled since the previous edge. If both enables rise at the same edge, the horizontal period starts one clock after the vertical period. Dropping the vertical enable stops the horizontal generator one clock later.
- R6: If WIDTH is equal to or greater than PERIOD, the sync output stays low for as long as the generator runs. If WIDTH is zero, the sync output never goes low.
- R7: A PERIOD of 0 or 1 is treated as a one-clock period, so the strobe is high on every running clock.
- R8: Suppose the vertical period is N times the horizontal period and both generators start together. Then every falling edge of the vertical sync is followed one clock later by a falling edge of the horizontal sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-component clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_en | input | 1 | Enable request for the horizontal generator |
| v_en | input | 1 | Enable for the vertical generator |
| h_period | input | CNT_W | Horizontal period in clocks |
| h_width | input | CNT_W | Horizontal sync low time in clocks |
| v_period | input | CNT_W | Vertical period in clocks |
| v_width | input | CNT_W | Vertical sync low time in clocks |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| h_wrap | output | 1 | One-clock strobe on the last clock of each horizontal period |
| v_wrap | output | 1 | One-clock strobe on the last clock of each vertical period |

## Verification
A directed line with period 12 and width 3 checks the low/high split and the strobe position against fixed clock indices. This separates an off-by-one in the width compare from one in the wrap compare. Short directed runs then cover:
- a width at or above the period (R6),
- a zero period (R7),
- a start with both enables together, which shows whether the one-clock interlock lag is present (R5),
- a frame of five lines, which checks the fixed vertical-to-horizontal phase (R8).

Random periods, widths and enable toggles, compared every clock with a bench model, exercise mid-period disables and restarts that the directed cases do not reach.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  localparam int unsigned NUM_SYNC = 2;
  localparam int unsigned CH_HORZ  = 0;
  localparam int unsigned CH_VERT  = 1;
endpackage

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] width,
  output logic             sync_n,
  output logic             wrap,
  output logic             active
);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             at_end;

  // zero or one period means every clock is the last
  assign at_end = (period == ZERO) || (cnt_q >= period - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= ZERO;
    end else if (!run_en) begin
      act_q <= 1'b0;
      cnt_q <= ZERO;
    end else begin
      act_q <= 1'b1;
      if (!act_q || at_end) cnt_q <= ZERO;
      else                  cnt_q <= cnt_q + ONE;
    end
  end

  assign sync_n = !(act_q && (cnt_q < width));
  assign wrap   = act_q && at_end;
  assign active = act_q;
endmodule

// File: rtl/sync_start_gate.sv
module sync_start_gate (
  input  logic h_req,
  input  logic v_running,
  output logic h_go
);
  // horizontal may only run behind an already running vertical generator
  assign h_go = h_req && v_running;
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_en,
  input  logic             v_en,
  input  logic [CNT_W-1:0] h_period,
  input  logic [CNT_W-1:0] h_width,
  input  logic [CNT_W-1:0] v_period,
  input  logic [CNT_W-1:0] v_width,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             h_wrap,
  output logic             v_wrap
);
  logic [NUM_SYNC-1:0]            run_vec;
  logic [NUM_SYNC-1:0]            sync_vec;
  logic [NUM_SYNC-1:0]            wrap_vec;
  logic [NUM_SYNC-1:0]            act_vec;
  logic [NUM_SYNC-1:0][CNT_W-1:0] per_arr;
  logic [NUM_SYNC-1:0][CNT_W-1:0] wid_arr;
  logic                           h_go;

  sync_start_gate u_gate (
    .h_req     (h_en),
    .v_running (act_vec[CH_VERT]),
    .h_go      (h_go)
  );

  assign run_vec[CH_HORZ] = h_go;
  assign run_vec[CH_VERT] = v_en;
  assign per_arr[CH_HORZ] = h_period;
  assign per_arr[CH_VERT] = v_period;
  assign wid_arr[CH_HORZ] = h_width;
  assign wid_arr[CH_VERT] = v_width;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_ch
    sync_pulse_gen #(.CNT_W(CNT_W)) u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_en (run_vec[g]),
      .period (per_arr[g]),
      .width  (wid_arr[g]),
      .sync_n (sync_vec[g]),
      .wrap   (wrap_vec[g]),
      .active (act_vec[g])
    );
  end

  assign hsync_n = sync_vec[CH_HORZ];
  assign vsync_n = sync_vec[CH_VERT];
  assign h_wrap  = wrap_vec[CH_HORZ];
  assign v_wrap  = wrap_vec[CH_VERT];
endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             h_en,
  input logic             v_en,
  input logic             h_go,
  input logic [CNT_W-1:0] h_period,
  input logic [CNT_W-1:0] h_width,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             h_wrap,
  input logic             v_wrap
);
  p_h_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !h_en |=> (hsync_n && !h_wrap));

  p_v_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !v_en |=> (vsync_n && !v_wrap));

  p_restart_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wrap && h_go && (h_width != '0)) |=> !hsync_n);

  p_wrap_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wrap && (h_period > 1)) |=> (!h_wrap || (h_period <= 1)));

  p_v_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> $past(v_en, 2));

  p_v_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !v_en |=> ##1 (hsync_n && !h_wrap));
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .h_en     (h_en),
  .v_en     (v_en),
  .h_go     (h_go),
  .h_period (h_period),
  .h_width  (h_width),
  .hsync_n  (hsync_n),
  .vsync_n  (vsync_n),
  .h_wrap   (h_wrap),
  .v_wrap   (v_wrap)
);

// File: tb/lcd_sync_gen_bench.sv
`timescale 1ns/1ps
module lcd_sync_gen_bench;
  localparam int CW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          h_en = 1'b0, v_en = 1'b0;
  logic [CW-1:0] h_period = '0, h_width = '0, v_period = '0, v_width = '0;
  logic          hsync_n, vsync_n, h_wrap, v_wrap;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench reference state
  bit m_h_act = 0, m_v_act = 0;
  int m_h_cnt = 0, m_v_cnt = 0;
  bit prev_vs = 1, prev_hs = 1, v_fell_last = 0;

  always #2.5 clk = ~clk;

  lcd_sync_gen #(.CNT_W(CW)) u_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .h_en(h_en), .v_en(v_en),
    .h_period(h_period), .h_width(h_width),
    .v_period(v_period), .v_width(v_width),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .h_wrap(h_wrap), .v_wrap(v_wrap)
  );

  function automatic bit last_clk(int cnt, int per);
    return (per <= 1) || (cnt >= per - 1);
  endfunction

  function automatic bit exp_sync_n(bit act, int cnt, int wid);
    return !(act && (cnt < wid));
  endfunction

  function automatic bit exp_wrap(bit act, int cnt, int per);
    return act && last_clk(cnt, per);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: advance reference with inputs held at the edge, then compare
  task automatic step();
    bit h_go;
    @(posedge clk);
    #1;
    h_go = h_en && m_v_act;
    if (!v_en) begin m_v_act = 0; m_v_cnt = 0; end
    else begin
      m_v_cnt = (!m_v_act || last_clk(m_v_cnt, int'(v_period))) ? 0 : m_v_cnt + 1;
      m_v_act = 1;
    end
    if (!h_go) begin m_h_act = 0; m_h_cnt = 0; end
    else begin
      m_h_cnt = (!m_h_act || last_clk(m_h_cnt, int'(h_period))) ? 0 : m_h_cnt + 1;
      m_h_act = 1;
    end
    chk(hsync_n == exp_sync_n(m_h_act, m_h_cnt, int'(h_width)), "R2 hsync_n model",
        hsync_n, exp_sync_n(m_h_act, m_h_cnt, int'(h_width)));
    chk(vsync_n == exp_sync_n(m_v_act, m_v_cnt, int'(v_width)), "R2 vsync_n model",
        vsync_n, exp_sync_n(m_v_act, m_v_cnt, int'(v_width)));
    chk(h_wrap == exp_wrap(m_h_act, m_h_cnt, int'(h_period)), "R3 h_wrap model",
        h_wrap, exp_wrap(m_h_act, m_h_cnt, int'(h_period)));
    chk(v_wrap == exp_wrap(m_v_act, m_v_cnt, int'(v_period)), "R3 v_wrap model",
        v_wrap, exp_wrap(m_v_act, m_v_cnt, int'(v_period)));
    v_fell_last = prev_vs && !vsync_n;
    prev_vs = vsync_n;
    prev_hs = hsync_n;
  endtask

  task automatic stop_all();
    h_en = 0; v_en = 0;
    step(); step();
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    #12;
    // R1 reset state
    chk(hsync_n == 1, "R1 hsync_n in reset", hsync_n, 1);
    chk(vsync_n == 1, "R1 vsync_n in reset", vsync_n, 1);
    chk(h_wrap == 0 && v_wrap == 0, "R1 strobes in reset", h_wrap | v_wrap, 0);
    rst_n = 1;
    step();
    chk(hsync_n && vsync_n && !h_wrap && !v_wrap, "R1 idle after reset",
        {hsync_n, vsync_n, h_wrap, v_wrap}, 4'b1100);

    // R2/R3 directed line: period 12, width 3
    h_period = 12; h_width = 3; v_period = 60; v_width = 24;
    v_en = 1; step();
    h_en = 1;
    for (int k = 0; k < 36; k++) begin
      step();
      chk(hsync_n == ((k % 12) >= 3), "R2 line low/high split", hsync_n, (k % 12) >= 3);
      chk(h_wrap == ((k % 12) == 11), "R3 strobe on last clock", h_wrap, (k % 12) == 11);
    end

    // R4 disable mid period then restart fresh
    h_en = 0; step();
    chk(hsync_n == 1 && h_wrap == 0, "R4 disabled output idle", hsync_n, 1);
    step();
    h_en = 1; step();
    chk(hsync_n == 0, "R4 fresh period after restart", hsync_n, 0);

    // R6 width >= period keeps sync low; width 0 never low
    stop_all();
    h_period = 5; h_width = 9; v_en = 1; h_en = 1; step();
    for (int k = 0; k < 10; k++) begin
      step();
      chk(hsync_n == 0, "R6 width over period stays low", hsync_n, 0);
    end
    h_width = 0;
    for (int k = 0; k < 10; k++) begin
      step();
      chk(hsync_n == 1, "R6 zero width never low", hsync_n, 1);
    end

    // R7 zero period wraps every clock
    h_period = 0;
    for (int k = 0; k < 5; k++) begin
      step();
      chk(h_wrap == 1, "R7 zero period strobe each clock", h_wrap, 1);
    end

    // R5 both enabled together: vertical leads by one clock
    stop_all();
    h_period = 12; h_width = 3; v_period = 60; v_width = 24;
    v_en = 1; h_en = 1;
    step();
    chk(vsync_n == 0 && hsync_n == 1, "R5 vertical starts first",
        {vsync_n, hsync_n}, 2'b01);
    step();
    chk(hsync_n == 0, "R5 horizontal one clock later", hsync_n, 0);
    // R8 fixed phase across several frames
    for (int k = 0; k < 250; k++) begin
      bit vf;
      vf = v_fell_last;
      step();
      if (vf) chk(prev_hs == 0 && hsync_n == 0, "R8 hsync falls one clock after vsync",
                  hsync_n, 0);
    end
    // R5 vertical drop stops horizontal a clock later
    v_en = 0; step();
    chk(vsync_n == 1, "R4 vertical idle after drop", vsync_n, 1);
    step();
    chk(hsync_n == 1 && h_wrap == 0, "R5 horizontal stops after vertical", hsync_n, 1);

    // random mix, checked each clock against the reference
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 40) == 0) begin
        h_period = CW'($urandom % 20);
        h_width  = CW'($urandom % 23);
        v_period = CW'($urandom % 61);
        v_width  = CW'($urandom % 64);
      end
      if (($urandom % 25) == 0) h_en = ~h_en;
      if (($urandom % 60) == 0) v_en = ~v_en;
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule